// File: doc/BRIEF.md
# Packet Access Port with Auto-Increment Pointer

This block lets a host reach individual bytes and 16-bit words inside packets held in a paged buffer memory. The host loads a pointer word, then moves data through a single data register. The pointer word carries a byte offset and three control flags. A source flag picks where the packet number comes from: the head of the receive queue (an input), or a packet-number register the host writes. An increment flag makes the offset advance after each data access. A read flag makes the port fetch the addressed word ahead of time.

Every data access forms a byte address as packet number × 256 + offset. The port drives a word-organised memory with one byte-enable per lane. Byte writes go to the lane chosen by offset bit 0. Byte reads return that lane in the low byte. Word accesses ignore offset bit 0. With the read flag set, loading the pointer starts a fetch of the addressed word. Each data read in increment mode then fetches the next word, so a data read returns held data at once. Inside each packet, offset 0 holds a status word and offset 2 holds a byte count whose bits 10:0 are significant. Offset 4 starts the destination address. The port only forms addresses and does not interpret this layout.

Top module: `pkt_access_port`

## Requirements
- R1: After reset, the pointer word reads 0, the packet number reads 0, a data read returns 0, and `mem_rd`, `mem_wr` and `fetch_pending` are low.
- R2: `host_sel` selects the register: 0 is the pointer, 1 is the packet number, 2 is data, and 3 is none. The pointer reads back bit 15 (source), bit 14 (increment), bit 13 (read) and the offset in bits 10:0, with every other bit 0. The packet number keeps only its low 4 bits. Writing a pointer word with bit 13 clear issues no memory command.
- R3: A data write issues exactly one memory write in the following cycle. Its word address is (packet × 256 + offset) / 2. The packet is `rxq_head` when pointer bit 15 is set and the packet-number register when it is clear, sampled at the time of the access.
- R4: A byte write (`host_word`=0) enables `mem_be[1]` at an odd offset and `mem_be[0]` at an even one, with the data byte on both lanes. A word write enables both lanes with the data unchanged, whatever offset bit 0 is.
- R5: With pointer bit 14 set, each data read or write advances the offset by 1 for a byte access and by 2 for a word access. The offset wraps modulo 2048.
- R6: With pointer bit 14 clear, data accesses leave the offset unchanged. Data reads then issue no memory command.
- R7: Writing a pointer word with bit 13 set issues a memory read of the new pointer's word in the next cycle. `fetch_pending` stays high until the word is held, two cycles after the pointer write. After that, a word data read returns the word.
- R8: A byte data read returns the lane selected by offset bit 0 in bits 7:0, with bits 15:8 zero.
- R9: A data read with pointer bits 13 and 14 set issues, in the next cycle, a memory read at the advanced offset.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle. `mem_rdata` is taken in the cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects for data reads only) |
| host_sel | input | 2 | Register select: 0 pointer, 1 packet number, 2 data |
| host_word | input | 1 | 1 = 16-bit data access, 0 = byte access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the selected register |
| rxq_head | input | 4 | Packet number at the head of the receive queue |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| mem_waddr | output | 12 | Memory word address |
| mem_be | output | 2 | Byte lane enables for writes |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| fetch_pending | output | 1 | A fetched word is still on its way |

## Verification
The checker watches every cycle for several things. It confirms that each data write turns into a memory write one cycle later, and that byte writes enable exactly one lane. It checks that the offset moves by the access width in increment mode and holds otherwise. It checks that pointer loads with the read flag start a fetch, and that read and write commands never overlap. Only the bench scenarios can show the values themselves. These include the word addresses formed from each packet source, the swap of `rxq_head` between accesses, the wrap at offset 2047, and which byte lane a byte read returns. They also include the data that comes back after a fetch, including a word written earlier through the port.

// File: rtl/pkt_port_pkg.sv
package pkt_port_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;

    // Pointer word control flag positions (the host encodes these)
    localparam int BIT_SRC = 15;
    localparam int BIT_INC = 14;
    localparam int BIT_RD  = 13;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_PNUM = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    typedef struct packed {
        logic src_rx;
        logic autoinc;
        logic rdmode;
    } ptr_ctl_t;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] data;
    } lane_wr_t;

    function automatic logic [1:0] step_of(input logic word);
        return word ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/pkt_ptr_regs.sv
module pkt_ptr_regs
    import pkt_port_pkg::*;
#(
    parameter int PKT_W = 4,
    parameter int OFS_W = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ptr_we,
    input  logic                 pnum_we,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 step_en,
    input  logic                 step_word,
    output ptr_ctl_t             ctl_q,
    output logic [OFS_W-1:0]     ofs_q,
    output logic [PKT_W-1:0]     pnum_q,
    output ptr_ctl_t             ctl_d,
    output logic [OFS_W-1:0]     ofs_d
);

    always_comb begin
        ctl_d = ctl_q;
        ofs_d = ofs_q;
        if (ptr_we) begin
            ctl_d.src_rx  = wdata[BIT_SRC];
            ctl_d.autoinc = wdata[BIT_INC];
            ctl_d.rdmode  = wdata[BIT_RD];
            ofs_d         = wdata[OFS_W-1:0];
        end else if (step_en && ctl_q.autoinc) begin
            ofs_d = ofs_q + OFS_W'(step_of(step_word));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            ofs_q  <= '0;
            pnum_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            ofs_q <= ofs_d;
            if (pnum_we) begin
                pnum_q <= wdata[PKT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pkt_addr_gen.sv
module pkt_addr_gen #(
    parameter int PKT_W   = 4,
    parameter int OFS_W   = 11,
    parameter int PAGE_SH = 8,
    parameter int ADDR_W  = 13
) (
    input  logic [PKT_W-1:0]   pkt,
    input  logic [OFS_W-1:0]   ofs,
    output logic [ADDR_W-2:0]  waddr
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] byte_addr;

    always_comb begin
        base      = ADDR_W'(pkt) << PAGE_SH;
        byte_addr = base + ADDR_W'(ofs);
        waddr     = byte_addr[ADDR_W-1:1];
    end

endmodule

// File: rtl/pkt_lane_mux.sv
module pkt_lane_mux
    import pkt_port_pkg::*;
(
    input  logic              word,
    input  logic              odd,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rword,
    output lane_wr_t          wr,
    output logic [WORD_W-1:0] rd_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            wr.be[g] = word || (odd == g[0]);
            wr.data[g*BYTE_W +: BYTE_W] = word ? wdata[g*BYTE_W +: BYTE_W]
                                               : wdata[BYTE_W-1:0];
        end
    end

    always_comb begin
        if (word) begin
            rd_out = rword;
        end else begin
            rd_out = '0;
            rd_out[BYTE_W-1:0] = odd ? rword[2*BYTE_W-1:BYTE_W] : rword[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/pkt_access_port.sv
module pkt_access_port
    import pkt_port_pkg::*;
#(
    parameter int PKT_W   = 4,
    parameter int OFS_W   = 11,
    parameter int PAGE_SH = 8,
    localparam int ADDR_W = ((PKT_W + PAGE_SH) > OFS_W ? (PKT_W + PAGE_SH) : OFS_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_sel,
    input  logic              host_word,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic [PKT_W-1:0]  rxq_head,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-2:0] mem_waddr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              fetch_pending
);

    port_sel_e sel;
    logic      ptr_we, pnum_we, data_wr, data_rd;

    assign sel     = port_sel_e'(host_sel);
    assign ptr_we  = host_wr && (sel == SEL_PTR);
    assign pnum_we = host_wr && (sel == SEL_PNUM);
    assign data_wr = host_wr && (sel == SEL_DATA);
    assign data_rd = host_rd && (sel == SEL_DATA);

    ptr_ctl_t         ctl_q, ctl_d;
    logic [OFS_W-1:0] ofs_q, ofs_d;
    logic [PKT_W-1:0] pnum_q;
    logic             inc_mode;

    pkt_ptr_regs #(.PKT_W(PKT_W), .OFS_W(OFS_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ptr_we    (ptr_we),
        .pnum_we   (pnum_we),
        .wdata     (host_wdata),
        .step_en   (data_wr || data_rd),
        .step_word (host_word),
        .ctl_q     (ctl_q),
        .ofs_q     (ofs_q),
        .pnum_q    (pnum_q),
        .ctl_d     (ctl_d),
        .ofs_d     (ofs_d)
    );

    assign inc_mode = ctl_q.autoinc;

    // Address for the access now, and for the word at the pointer's next state
    logic [PKT_W-1:0]  pkt_cur, pkt_nxt;
    logic [ADDR_W-2:0] waddr_cur, waddr_nxt;

    assign pkt_cur = ctl_q.src_rx ? rxq_head : pnum_q;
    assign pkt_nxt = ctl_d.src_rx ? rxq_head : pnum_q;

    pkt_addr_gen #(.PKT_W(PKT_W), .OFS_W(OFS_W), .PAGE_SH(PAGE_SH), .ADDR_W(ADDR_W)) u_addr_cur (
        .pkt   (pkt_cur),
        .ofs   (ofs_q),
        .waddr (waddr_cur)
    );

    pkt_addr_gen #(.PKT_W(PKT_W), .OFS_W(OFS_W), .PAGE_SH(PAGE_SH), .ADDR_W(ADDR_W)) u_addr_nxt (
        .pkt   (pkt_nxt),
        .ofs   (ofs_d),
        .waddr (waddr_nxt)
    );

    // Lane handling
    lane_wr_t          lane_wr;
    logic [WORD_W-1:0] pf_q;
    logic [WORD_W-1:0] rd_lane;

    pkt_lane_mux u_lanes (
        .word   (host_word),
        .odd    (ofs_q[0]),
        .wdata  (host_wdata),
        .rword  (pf_q),
        .wr     (lane_wr),
        .rd_out (rd_lane)
    );

    // Memory command register
    logic req_rd;
    logic rd_inflight;

    assign req_rd = (ptr_we && host_wdata[BIT_RD])
                 || (data_rd && ctl_q.rdmode && inc_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_rd      <= 1'b0;
            mem_wr      <= 1'b0;
            mem_waddr   <= '0;
            mem_be      <= '0;
            mem_wdata   <= '0;
            rd_inflight <= 1'b0;
            pf_q        <= '0;
        end else begin
            mem_rd      <= req_rd;
            mem_wr      <= data_wr;
            mem_waddr   <= data_wr ? waddr_cur : waddr_nxt;
            mem_be      <= data_wr ? lane_wr.be : '0;
            mem_wdata   <= lane_wr.data;
            rd_inflight <= mem_rd;
            if (rd_inflight) begin
                pf_q <= mem_rdata;
            end
        end
    end

    assign fetch_pending = mem_rd || rd_inflight;

    // Host read mux
    always_comb begin
        host_rdata = '0;
        case (sel)
            SEL_PTR: begin
                host_rdata[OFS_W-1:0] = ofs_q;
                host_rdata[BIT_SRC]   = ctl_q.src_rx;
                host_rdata[BIT_INC]   = ctl_q.autoinc;
                host_rdata[BIT_RD]    = ctl_q.rdmode;
            end
            SEL_PNUM: host_rdata[PKT_W-1:0] = pnum_q;
            SEL_DATA: host_rdata = rd_lane;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pkt_access_port_chk.sv
module pkt_access_port_chk
    import pkt_port_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_sel,
    input logic             host_word,
    input logic [15:0]      host_wdata,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [1:0]       mem_be,
    input logic [OFS_W-1:0] ofs_q,
    input logic             autoinc_q
);

    logic             data_acc;
    logic [OFS_W-1:0] nxt_ofs;

    assign data_acc = (host_wr || host_rd) && (host_sel == SEL_DATA);
    assign nxt_ofs  = ofs_q + (host_word ? OFS_W'(2) : OFS_W'(1));

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_rd && !mem_wr));

    a_r3_write_issued: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == SEL_DATA) |=> mem_wr);

    a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == SEL_DATA && !host_word) |=> ($countones(mem_be) == 1));

    a_r5_step_width: assert property (@(posedge clk) disable iff (rst)
        (data_acc && autoinc_q) |=> (ofs_q == $past(nxt_ofs)));

    a_r6_offset_hold: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !autoinc_q) |=> $stable(ofs_q));

    a_r7_prefetch_start: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == SEL_PTR && host_wdata[BIT_RD]) |=> mem_rd);

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

bind pkt_access_port pkt_access_port_chk #(.OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_sel   (host_sel),
    .host_word  (host_word),
    .host_wdata (host_wdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_be     (mem_be),
    .ofs_q      (ofs_q),
    .autoinc_q  (inc_mode)
);

// File: tb/pkt_access_port_test.sv
`timescale 1ns/1ps
module pkt_access_port_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr, host_rd, host_word;
    logic [1:0]  host_sel;
    logic [15:0] host_wdata, host_rdata;
    logic [3:0]  rxq_head;
    logic        mem_rd, mem_wr, fetch_pending;
    logic [11:0] mem_waddr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, mem_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pkt_access_port uut (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rxq_head(rxq_head),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_waddr(mem_waddr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fetch_pending(fetch_pending)
    );

    // Memory model: word array, one-cycle read latency, lane enables
    logic [15:0] tmem [0:4095];

    function automatic logic [15:0] pat(input logic [11:0] w);
        return 16'({4'b0, w} * 16'h0107 + 16'h2B3C);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4096; i++) tmem[i] <= pat(12'(i));
            mem_rdata <= '0;
        end else begin
            if (mem_rd) mem_rdata <= tmem[mem_waddr];
            if (mem_wr) begin
                if (mem_be[0]) tmem[mem_waddr][7:0]  <= mem_wdata[7:0];
                if (mem_be[1]) tmem[mem_waddr][15:8] <= mem_wdata[15:8];
            end
        end
    end

    localparam logic [1:0] S_PTR = 2'd0, S_PNUM = 2'd1, S_DATA = 2'd2, S_NONE = 2'd3;

    logic        cap_rd, cap_wr;
    logic [11:0] cap_addr;
    logic [1:0]  cap_be;
    logic [15:0] cap_wd;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic capture();
        cap_rd   = mem_rd;
        cap_wr   = mem_wr;
        cap_addr = mem_waddr;
        cap_be   = mem_be;
        cap_wd   = mem_wdata;
    endtask

    task automatic do_wr(input logic [1:0] sel, input logic word, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_word = word; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_sel = S_NONE;
        capture();
    endtask

    task automatic do_rd(input logic [1:0] sel, input logic word, output logic [15:0] q);
        @(negedge clk);
        host_rd = 1'b1; host_sel = sel; host_word = word;
        #1 q = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; host_sel = S_NONE;
        capture();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        logic [15:0] q;
        check("R1 mem_rd", 32'(mem_rd), 0);
        check("R1 mem_wr", 32'(mem_wr), 0);
        check("R1 fetch_pending", 32'(fetch_pending), 0);
        do_rd(S_PTR, 1'b1, q);  check("R1 pointer", 32'(q), 0);
        do_rd(S_PNUM, 1'b1, q); check("R1 pnum", 32'(q), 0);
        do_rd(S_DATA, 1'b1, q); check("R1 data", 32'(q), 0);
    endtask

    // R2
    task automatic t_regs();
        logic [15:0] q;
        do_wr(S_PNUM, 1'b1, 16'hFFF5);
        do_rd(S_PNUM, 1'b1, q); check("R2 pnum low bits", 32'(q), 32'h5);
        do_wr(S_PTR, 1'b1, 16'h5FFF);
        check("R2 no fetch without read flag", 32'(cap_rd), 0);
        do_rd(S_PTR, 1'b1, q); check("R2 pointer readback", 32'(q), 32'h47FF);
    endtask

    // R3 R4 R6
    task automatic t_word_write();
        logic [15:0] q;
        do_wr(S_PTR, 1'b1, 16'h0010);
        do_wr(S_DATA, 1'b1, 16'hBEEF);
        check("R3 write issued", 32'(cap_wr), 1);
        check("R10 no read with write", 32'(cap_rd), 0);
        check("R3 addr pnum", 32'(cap_addr), 32'h288);
        check("R4 word be", 32'(cap_be), 32'h3);
        check("R4 word data", 32'(cap_wd), 32'hBEEF);
        do_rd(S_PTR, 1'b1, q); check("R6 offset held", 32'(q), 32'h0010);
    endtask

    // R4 R5
    task automatic t_byte_inc();
        logic [15:0] q;
        do_wr(S_PTR, 1'b1, 16'h4021);
        do_wr(S_DATA, 1'b0, 16'h0077);
        check("R3 byte addr odd", 32'(cap_addr), 32'h290);
        check("R4 odd lane be", 32'(cap_be), 32'h2);
        check("R4 odd lane data", 32'(cap_wd[15:8]), 32'h77);
        do_wr(S_DATA, 1'b0, 16'h0066);
        check("R3 byte addr even", 32'(cap_addr), 32'h291);
        check("R4 even lane be", 32'(cap_be), 32'h1);
        check("R4 even lane data", 32'(cap_wd[7:0]), 32'h66);
        do_rd(S_PTR, 1'b1, q); check("R5 byte steps", 32'(q), 32'h4023);
        do_wr(S_DATA, 1'b1, 16'hA1B2);
        check("R4 word at odd offset addr", 32'(cap_addr), 32'h291);
        check("R4 word at odd offset be", 32'(cap_be), 32'h3);
        do_rd(S_PTR, 1'b1, q); check("R5 word step", 32'(q), 32'h4025);
    endtask

    // R3 receive-queue source
    task automatic t_rx_source();
        rxq_head = 4'd3;
        do_wr(S_PTR, 1'b1, 16'hC004);
        do_wr(S_DATA, 1'b1, 16'h1234);
        check("R3 addr rx head 3", 32'(cap_addr), 32'h182);
        rxq_head = 4'd7;
        do_wr(S_DATA, 1'b1, 16'h5678);
        check("R3 addr rx head 7", 32'(cap_addr), 32'h383);
    endtask

    // R5 wrap
    task automatic t_wrap();
        logic [15:0] q;
        do_wr(S_PTR, 1'b1, 16'h47FF);
        do_wr(S_DATA, 1'b0, 16'h0011);
        check("R3 addr at top offset", 32'(cap_addr), 32'h67F);
        do_rd(S_PTR, 1'b1, q); check("R5 byte wrap", 32'(q), 32'h4000);
        do_wr(S_PTR, 1'b1, 16'h47FE);
        do_wr(S_DATA, 1'b1, 16'h0022);
        do_rd(S_PTR, 1'b1, q); check("R5 word wrap", 32'(q), 32'h4000);
    endtask

    // R7 R6 R9
    task automatic t_prefetch();
        logic [15:0] q;
        do_wr(S_PNUM, 1'b1, 16'h0002);
        do_wr(S_PTR, 1'b1, 16'h2040);
        check("R7 fetch issued", 32'(cap_rd), 1);
        check("R7 fetch addr", 32'(cap_addr), 32'h120);
        check("R7 pending", 32'(fetch_pending), 1);
        idle(1);
        check("R7 pending second cycle", 32'(fetch_pending), 1);
        idle(1);
        check("R7 pending done", 32'(fetch_pending), 0);
        do_rd(S_DATA, 1'b1, q); check("R7 word returned", 32'(q), 32'(pat(12'h120)));
        check("R6 no refetch without inc", 32'(cap_rd), 0);
        do_rd(S_DATA, 1'b1, q); check("R6 same word again", 32'(q), 32'(pat(12'h120)));
    endtask

    // R8 R9
    task automatic t_byte_read();
        logic [15:0] q;
        do_wr(S_PTR, 1'b1, 16'h6041);
        idle(2);
        do_rd(S_DATA, 1'b0, q);
        check("R8 odd lane byte", 32'(q), 32'({8'h00, pat(12'h120)}[15:8]));
        check("R9 refetch issued", 32'(cap_rd), 1);
        check("R9 refetch addr", 32'(cap_addr), 32'h121);
        idle(2);
        do_rd(S_DATA, 1'b0, q);
        check("R8 even lane byte", 32'(q), 32'(pat(12'h121)[7:0]));
        idle(2);
        do_rd(S_DATA, 1'b1, q);
        check("R8 word read ignores bit0", 32'(q), 32'(pat(12'h121)));
        do_rd(S_PTR, 1'b1, q); check("R5 read steps", 32'(q), 32'h6045);
    endtask

    // R3 R7 round trip through rx source
    task automatic t_roundtrip();
        logic [15:0] q;
        rxq_head = 4'd3;
        do_wr(S_PTR, 1'b1, 16'hA004);
        check("R7 fetch addr rx", 32'(cap_addr), 32'h182);
        idle(2);
        do_rd(S_DATA, 1'b1, q); check("R3 written word read back", 32'(q), 32'h1234);
    endtask

    initial begin
        rst = 1'b1; host_wr = 1'b0; host_rd = 1'b0; host_word = 1'b0;
        host_sel = S_NONE; host_wdata = '0; rxq_head = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_word_write();
        t_byte_inc();
        t_rx_source();
        t_wrap();
        t_prefetch();
        t_byte_read();
        t_roundtrip();
        idle(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule